// File: doc/BRIEF.md
# Shared Load/Store Unit Arbiter

This block is the front end of a single memory execution unit that four scheduler partitions share. Each partition pushes load/store requests into a private queue. A request holds a warp id, an access-width flag, one address per thread and a bank-conflict degree. The unit serves the partitions in turn. It resolves all thread addresses of the granted request in one cycle. It then streams the result over one return path, one beat per cycle.

The number of beats depends on the access. A 32-bit access with no conflict fits the return path in one beat. A 64-bit-per-thread access needs a second beat. A bank conflict of degree k adds k-1 beats. Each beat is flagged only toward the partition that made the request. The beat also carries that partition's index and the warp id, so the requester can match it to its request. The cache and shared-memory arrays are outside this block. They are modelled as a source that always hits: the data in each lane is derived from that thread's address.

Top module: `lsu_share_arb`

## Requirements
- R1: Each partition queue holds up to 4 entries. `req_ready[p]` is low exactly when queue p holds 4 entries. A push takes place on a clock edge where `req_valid[p]` and `req_ready[p]` are both high. A push while `req_ready[p]` is low is dropped and never returns a beat.
- R2: When the unit takes a new request, it searches for a non-empty queue starting at the partition after the one granted last, in increasing index order with wrap-around. Empty queues are skipped. After reset the search starts at partition 0.
- R3: A granted request keeps the return path on consecutive cycles until its last beat. Its beat index counts 0, 1, … up to n-1 and `ret_last` marks beat n-1. Beats of different requests are never interleaved. The next request may start on the cycle right after a last beat.
- R4: A 32-bit access (`req_wide`=0) with conflict degree 0 or 1 returns a single beat. If it is pushed into an empty, idle unit at edge E, its beat is presented in the cycle after edge E+1.
- R5: A 64-bit-per-thread access (`req_wide`=1) adds one beat: 2 beats when there is no conflict.
- R6: A conflict degree k (3-bit field `req_conf`) of 2 or more adds k-1 beats. The beat count is 1 + wide + max(k-1, 0).
- R7: In beat b, lane i of `ret_data` (bits i*8 +: 8) equals thread i's address lane (bits i*8 +: 8 of the pushed address vector) plus b, modulo 256.
- R8: While a beat is presented, `ret_valid` is one-hot at the requesting partition's bit. `ret_part` gives that partition's index and `ret_warp` gives the request's warp id. No other partition sees a valid beat.
- R9: After reset all queues are empty, every `req_ready` bit is high and `ret_valid` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Push strobe, one per partition |
| req_ready | output | 4 | Queue has space, one per partition |
| req_warp | input | 20 | Warp id, 5 bits per partition |
| req_wide | input | 4 | 64-bit-per-thread access flag, one per partition |
| req_conf | input | 12 | Bank-conflict degree, 3 bits per partition |
| req_addr | input | 1024 | 32 thread addresses of 8 bits, 256 bits per partition |
| ret_valid | output | 4 | Return beat valid, one-hot at the requester |
| ret_part | output | 2 | Partition index of the current beat |
| ret_warp | output | 5 | Warp id of the current beat |
| ret_beat | output | 4 | Beat index within the request |
| ret_last | output | 1 | Final beat of the request |
| ret_data | output | 256 | Per-thread return lanes |

## Verification
Several internal faults would show at the ports, each at a known point:
- A wrong round-robin pointer sends the next grant to the wrong partition. This shows in `ret_valid` in the first cycle of that request.
- A wrong beat counter or beat-count computation moves `ret_last` early or late. This shows within the same request.
- A queue count that drifts shows in `req_ready` on the edge after the drift. It also shows later, as a missing or extra returned request.

A reference model with behavioural queues is compared with every output on every clock. Each divergence is therefore reported in the cycle where it first appears.

// File: rtl/lsu_share_arb.sv
module lsu_share_arb #(
  parameter int NPART  = 4,
  parameter int QDEPTH = 4,
  parameter int NTHR   = 32,
  parameter int AW     = 8,
  parameter int WW     = 5,
  parameter int CW     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPART-1:0]      req_valid,
  output logic [NPART-1:0]      req_ready,
  input  logic [NPART*WW-1:0]   req_warp,
  input  logic [NPART-1:0]      req_wide,
  input  logic [NPART*CW-1:0]   req_conf,
  input  logic [NPART*NTHR*AW-1:0] req_addr,
  output logic [NPART-1:0]      ret_valid,
  output logic [$clog2(NPART)-1:0] ret_part,
  output logic [WW-1:0]         ret_warp,
  output logic [$clog2(2**CW+2)-1:0] ret_beat,
  output logic                  ret_last,
  output logic [NTHR*AW-1:0]    ret_data
);
  localparam int PW   = $clog2(NPART);
  localparam int BW   = $clog2(2**CW+2);
  localparam int LW   = NTHR*AW;
  localparam int QW   = $clog2(QDEPTH);
  localparam int CNTW = $clog2(QDEPTH+1);
  localparam int EW   = WW+1+CW+LW;

  logic [EW-1:0]   qmem [NPART][QDEPTH];
  logic [QW-1:0]   wp [NPART];
  logic [QW-1:0]   rp [NPART];
  logic [CNTW-1:0] cnt [NPART];

  logic            busy;
  logic [PW-1:0]   ptr, cur, gsel;
  logic [EW-1:0]   act, head;
  logic [BW-1:0]   beat, lastb, lastb_n;
  logic            grant_ok, last, take;

  always_comb begin
    grant_ok = 1'b0;
    gsel     = ptr;
    for (int i = NPART; i >= 1; i--) begin
      if (cnt[(int'(ptr) + i) % NPART] != '0) begin
        grant_ok = 1'b1;
        gsel     = PW'((int'(ptr) + i) % NPART);
      end
    end
  end

  assign head    = qmem[gsel][rp[gsel]];
  assign lastb_n = BW'(head[LW+CW]) +
                   ((head[LW +: CW] > CW'(1)) ? BW'(head[LW +: CW] - CW'(1)) : BW'(0));
  assign last    = busy && (beat == lastb);
  assign take    = (!busy || last) && grant_ok;

  always_comb
    for (int p = 0; p < NPART; p++)
      req_ready[p] = (cnt[p] != CNTW'(QDEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= PW'(NPART-1);
      cur  <= '0;
      beat <= '0;
      lastb <= '0;
      for (int p = 0; p < NPART; p++) begin
        wp[p]  <= '0;
        rp[p]  <= '0;
        cnt[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NPART; p++) begin
        if (req_valid[p] && req_ready[p]) begin
          qmem[p][wp[p]] <= {req_warp[p*WW +: WW], req_wide[p],
                             req_conf[p*CW +: CW], req_addr[p*LW +: LW]};
          wp[p] <= wp[p] + QW'(1);
        end
        if (take && gsel == PW'(p)) rp[p] <= rp[p] + QW'(1);
        cnt[p] <= cnt[p] + CNTW'(req_valid[p] && req_ready[p])
                         - CNTW'(take && gsel == PW'(p));
      end
      if (take) begin
        act   <= head;
        cur   <= gsel;
        ptr   <= gsel;
        beat  <= '0;
        lastb <= lastb_n;
        busy  <= 1'b1;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        beat <= beat + BW'(1);
      end
    end
  end

  assign ret_valid = busy ? (NPART'(1) << cur) : '0;
  assign ret_part  = cur;
  assign ret_warp  = act[EW-1 -: WW];
  assign ret_beat  = beat;
  assign ret_last  = last;

  for (genvar i = 0; i < NTHR; i++) begin : g_lane
    assign ret_data[i*AW +: AW] = act[i*AW +: AW] + AW'(beat);
  end
endmodule

// File: rtl/lsu_share_arb_chk.sv
module lsu_share_arb_chk #(
  parameter int NPART = 4,
  parameter int WW    = 5,
  parameter int BW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPART-1:0] ret_valid,
  input logic [$clog2(NPART)-1:0] ret_part,
  input logic [WW-1:0]    ret_warp,
  input logic [BW-1:0]    ret_beat,
  input logic             ret_last
);
  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ret_valid));

  // R8
  part_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != '0) |-> (ret_valid == (NPART'(1) << ret_part)));

  // R3
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != '0 && !ret_last) |=>
      (ret_valid == $past(ret_valid) && ret_warp == $past(ret_warp) &&
       ret_beat == $past(ret_beat) + 1'b1));

  // R3
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != '0 && ret_last) |=> (ret_valid == '0 || ret_beat == '0));
endmodule

bind lsu_share_arb lsu_share_arb_chk #(.NPART(NPART), .WW(WW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_part(ret_part),
  .ret_warp(ret_warp), .ret_beat(ret_beat), .ret_last(ret_last));

// File: tb/tb_lsu_share_arb.sv
`timescale 1ns/1ps
module tb_lsu_share_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]    req_valid = '0, req_ready, req_wide = '0, ret_valid;
  logic [19:0]   req_warp = '0;
  logic [11:0]   req_conf = '0;
  logic [1023:0] req_addr = '0;
  logic [1:0]    ret_part;
  logic [4:0]    ret_warp;
  logic [3:0]    ret_beat;
  logic          ret_last;
  logic [255:0]  ret_data;

  always #2 clk = ~clk;

  lsu_share_arb dut (.*);

  typedef struct { int warp; bit wide; int conf; logic [255:0] addr; } req_t;
  req_t mq [4][$];
  req_t m_act;
  bit   m_busy, m_last, m_found;
  bit   m_rdy [4];
  int   m_ptr, m_part, m_beat, m_n;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) mq[p].delete();
      m_busy = 0; m_ptr = 3; m_beat = 0; m_part = 0; m_n = 1;
    end else begin
      for (int p = 0; p < 4; p++) m_rdy[p] = mq[p].size() < 4;
      m_last = m_busy && (m_beat == m_n - 1);
      if (!m_busy || m_last) begin
        m_found = 0;
        for (int i = 1; i <= 4; i++) begin
          int j;
          j = (m_ptr + i) % 4;
          if (!m_found && mq[j].size() > 0) begin
            m_found = 1;
            m_act = mq[j].pop_front();
            m_part = j; m_ptr = j; m_beat = 0; m_busy = 1;
            m_n = 1 + int'(m_act.wide) + ((m_act.conf > 1) ? m_act.conf - 1 : 0);
          end
        end
        if (!m_found) m_busy = 0;
      end else if (m_busy) m_beat++;
      for (int p = 0; p < 4; p++)
        if (req_valid[p] && m_rdy[p]) begin
          req_t e;
          e.warp = int'(req_warp[p*5 +: 5]); e.wide = req_wide[p];
          e.conf = int'(req_conf[p*3 +: 3]); e.addr = req_addr[p*256 +: 256];
          mq[p].push_back(e);
        end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ev;
      logic [255:0] ed;
      string bt;
      for (int p = 0; p < 4; p++)
        chk(req_ready[p] == (mq[p].size() < 4), "R1", "ready", 256'(req_ready[p]),
            256'(mq[p].size() < 4));
      ev = m_busy ? (4'b1 << m_part) : 4'b0;
      chk(ret_valid == ev, "R2", "ret_valid", 256'(ret_valid), 256'(ev));
      if (m_busy && ret_valid == ev) begin
        bt = m_act.wide ? "R5" : (m_act.conf > 1 ? "R6" : "R4");
        chk(ret_part == 2'(m_part), "R8", "ret_part", 256'(ret_part), 256'(m_part));
        chk(ret_warp == 5'(m_act.warp), "R8", "ret_warp", 256'(ret_warp), 256'(m_act.warp));
        chk(ret_beat == 4'(m_beat), "R3", "ret_beat", 256'(ret_beat), 256'(m_beat));
        chk(ret_last == (m_beat == m_n - 1), bt, "ret_last", 256'(ret_last),
            256'(m_beat == m_n - 1));
        for (int i = 0; i < 32; i++) ed[i*8 +: 8] = m_act.addr[i*8 +: 8] + 8'(m_beat);
        chk(ret_data == ed, "R7", "ret_data", ret_data, ed);
      end
    end
  end

  function automatic logic [255:0] rnd_addr();
    logic [255:0] a;
    for (int k = 0; k < 8; k++) a[k*32 +: 32] = $urandom;
    return a;
  endfunction

  task automatic set_req(int p, int warp, bit wide, int conf);
    req_valid[p] = 1'b1;
    req_warp[p*5 +: 5] = 5'(warp);
    req_wide[p] = wide;
    req_conf[p*3 +: 3] = 3'(conf);
    req_addr[p*256 +: 256] = rnd_addr();
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    req_valid = '0;
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    int seen_full;
    step(); step();
    rst_n = 1'b1;
    step();
    // R9: reset state
    chk(req_ready == 4'hF, "R9", "ready after reset", 256'(req_ready), 256'hF);
    chk(ret_valid == 4'h0, "R9", "valid after reset", 256'(ret_valid), 256'h0);

    // R4: single narrow request latency
    set_req(0, 7, 0, 0);
    step(); req_valid = '0;
    step();
    chk(ret_valid == 4'b0001, "R4", "first beat timing", 256'(ret_valid), 256'h1);
    chk(ret_last == 1'b1, "R4", "single beat", 256'(ret_last), 256'h1);
    idle(3);

    // R5, R6: wide, conflicted and combined
    set_req(1, 3, 1, 0); step(); idle(4);
    set_req(2, 9, 0, 3); step(); idle(5);
    set_req(3, 31, 1, 4); step(); idle(7);

    // R2: all four at once, twice
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 4; p++) set_req(p, p + 4*r, r, p);
      step();
    end
    idle(30);

    // R1: fill partition 0 behind a long request
    set_req(1, 12, 1, 7); step();
    seen_full = 0;
    for (int k = 0; k < 8; k++) begin
      set_req(0, k, 0, 0);
      req_valid[1] = 1'b0;
      step();
      if (req_ready[0] == 1'b0) seen_full = 1;
    end
    chk(seen_full == 1, "R1", "queue full seen", 256'(seen_full), 256'h1);
    idle(40);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < 4; p++) begin
        if ($urandom_range(0, 3) == 0) set_req(p, $urandom_range(0, 31),
            1'($urandom_range(0, 1)), $urandom_range(0, 7));
        else req_valid[p] = 1'b0;
      end
      step();
    end
    idle(200);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule